// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Interrupts

A register-mapped general-purpose I/O bank for up to 32 pins, reached over a plain 32-bit read/write bus with one-cycle read latency. For every pin it works out the level the pin settles at. An external device that drives the pin wins. If no external device drives it, the pin's own enabled output wins. If neither drives it, the pull-up setting decides. The block's own output is the stored port bit passed through a per-pin inversion mask.

The resolved level, gated by a per-pin input enable, is captured every clock into a read-only sample register. Comparing each new sample with the stored one feeds four sticky pending flags per pin: level high, level low, rising edge and falling edge. Each of the four has its own enable mask. A pin's interrupt line is raised when any enabled pending flag of that pin is set. The pending registers are cleared by writing ones. The block also reports, per pin, when an external driver and its own output drive the same pin at once. External inputs pass through a two-flop synchronizer before use.

The drive-strength and alternate-function registers are plain read/write storage with no effect on the pins.

Top module: `gpio_bank`

## Requirements
- R1: With no external drive and output enable set, a pin's resolved level (`pin_level`) equals its port bit XOR its inversion bit.
- R2: Level priority is external drive first (`pin_drv`=1 selects `pin_in`), then own drive (output enable), then the pull-up bit; a pin with none of the three reads level 0.
- R3: `pin_short` bit i is 1 exactly when pin i is externally driven and its output enable is set.
- R4: Each clock the sample register (offset 0x00, read-only) stores input-enable AND resolved level per pin; with the input enable clear the sample bit is 0.
- R5: The level-high pending flag (0x2C) sets whenever a pin's new sample is 1, and the level-low pending flag (0x34) sets whenever it is 0; both stay set until cleared.
- R6: The rising pending flag (0x1C) sets when the new sample is 1 and the stored sample was 0; the falling pending flag (0x24) sets on the opposite change.
- R7: Writing a pending register clears only the bits written as 1; when a bit is set and cleared in the same cycle, the set wins.
- R8: `pin_irq` bit i is the OR over the four kinds of (pending AND enable) for pin i, with enables at 0x18 rising, 0x20 falling, 0x28 high, 0x30 low; it follows the pending state one clock later.
- R9: Reset clears every register, the synchronizer and all outputs to zero.
- R10: Input enable 0x04, output enable 0x08, port 0x0C, pull-up 0x10, drive strength 0x14, alternate enable 0x38, alternate select 0x3C and inversion 0x40 read back the last written value; drive strength and the alternate registers have no effect on pin levels.
- R11: A read or write at an unmapped offset (above 0x40 or not a multiple of 4), or a write to the sample register, is ignored, reads 0, and pulses `bus_bad` high on the following clock.
- R12: A change on `pin_in` or `pin_drv` reaches `pin_level` on the third clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returns one cycle later |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read was made |
| bus_bad | output | 1 | Pulses after an access to an unmapped offset or a write to the sample register |
| pin_in | input | 32 | Level driven by an external device, per pin |
| pin_drv | input | 32 | Per pin: the external device is driving the pin |
| pin_level | output | 32 | Resolved level of each pin |
| pin_short | output | 32 | Per pin: external and own drive collide |
| pin_irq | output | 32 | Per-pin interrupt line |

## Verification
The assertions check, on every cycle, the properties that tie one clock to the next: pending flags never drop without a clear, a change in the stored sample always leaves the matching edge flag set, a disabled input always samples 0, a colliding pin shows the external level, an interrupt needs an enable, and a bad read returns zero. The bench's scenarios are needed for the value-level behaviour: the three-way priority under mixed patterns, inversion, partial write-1-to-clear, a level flag re-setting through its own clear, the interrupt combining across four kinds, readback of storage-only registers, and the synchronizer latency counted edge by edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_COUNT = 17;

  // Word index of each register (byte offset = index * 4).
  typedef enum logic [4:0] {
    IX_SAMPLE    = 5'd0,
    IX_IN_EN     = 5'd1,
    IX_OUT_EN    = 5'd2,
    IX_OUT_VAL   = 5'd3,
    IX_PULL_EN   = 5'd4,
    IX_DRIVE     = 5'd5,
    IX_RISE_EN   = 5'd6,
    IX_RISE_PEND = 5'd7,
    IX_FALL_EN   = 5'd8,
    IX_FALL_PEND = 5'd9,
    IX_HIGH_EN   = 5'd10,
    IX_HIGH_PEND = 5'd11,
    IX_LOW_EN    = 5'd12,
    IX_LOW_PEND  = 5'd13,
    IX_ALT_EN    = 5'd14,
    IX_ALT_SEL   = 5'd15,
    IX_OUT_INV   = 5'd16
  } reg_ix_e;

  // One bit per interrupt kind for a single pin.
  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
    logic low;
  } evt_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic ext_drv,
  input  logic in_en,
  input  logic out_en,
  input  logic out_val,
  input  logic out_inv,
  input  logic pull_en,
  input  evt_t ie,
  input  evt_t clr,
  output logic level_q,
  output logic short_q,
  output logic sample_q,
  output evt_t pend_q,
  output logic irq_q
);

  logic own_lvl;
  logic level_c;
  logic samp_c;
  evt_t set_c;
  evt_t pend_n;

  // Own drive, then three-way priority.
  assign own_lvl = out_en & (out_val ^ out_inv);

  always_comb begin
    if (ext_drv)     level_c = ext_in;
    else if (out_en) level_c = own_lvl;
    else             level_c = pull_en;
  end

  assign samp_c = in_en & level_c;

  always_comb begin
    set_c.rise = samp_c & ~sample_q;
    set_c.fall = ~samp_c & sample_q;
    set_c.high = samp_c;
    set_c.low  = ~samp_c;
    // A set in the same cycle as a clear wins.
    pend_n = evt_t'((pend_q & ~clr) | set_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= 1'b0;
      short_q  <= 1'b0;
      sample_q <= 1'b0;
      pend_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      level_q  <= level_c;
      short_q  <= ext_drv & out_en;
      sample_q <= samp_c;
      pend_q   <= pend_n;
      irq_q    <= |(pend_q & ie);
    end
  end

  AST_HIGH_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q.high) && !$past(clr.high)) |-> pend_q.high); // R5
  AST_LOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q.low) && !$past(clr.low)) |-> pend_q.low); // R5
  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_q) |-> pend_q.rise); // R6
  AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_q) |-> pend_q.fall); // R6
  AST_SAMPLE_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(in_en) |-> !sample_q); // R4
  AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
    short_q |-> (level_q == $past(ext_in))); // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|ie)); // R8

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_bad,
  output logic [NPINS-1:0]        in_en,
  output logic [NPINS-1:0]        out_en,
  output logic [NPINS-1:0]        out_val,
  output logic [NPINS-1:0]        pull_en,
  output logic [NPINS-1:0]        out_inv,
  output evt_t [NPINS-1:0]        ie,
  output evt_t [NPINS-1:0]        clr,
  input  logic [NPINS-1:0]        sample,
  input  evt_t [NPINS-1:0]        pend
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             mapped;
  reg_ix_e          ix;
  logic             wr_ok;
  logic             bad_c;
  logic [NPINS-1:0] wd;

  logic [NPINS-1:0] drive_q, alt_en_q, alt_sel_q;
  logic [NPINS-1:0] rise_en_q, fall_en_q, high_en_q, low_en_q;
  logic [NPINS-1:0] rise_p, fall_p, high_p, low_p;
  logic [DATA_W-1:0] rd_mux;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign mapped = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(REG_COUNT));
  assign ix     = reg_ix_e'(idx[4:0]);
  assign wr_ok  = bus_wr && mapped && (ix != IX_SAMPLE);
  assign bad_c  = ((bus_wr || bus_rd) && !mapped) ||
                  (bus_wr && mapped && (ix == IX_SAMPLE));
  assign wd     = bus_wdata[NPINS-1:0];

  // Plain storage registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_en     <= '0;
      out_en    <= '0;
      out_val   <= '0;
      pull_en   <= '0;
      out_inv   <= '0;
      drive_q   <= '0;
      alt_en_q  <= '0;
      alt_sel_q <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      high_en_q <= '0;
      low_en_q  <= '0;
    end else if (wr_ok) begin
      case (ix)
        IX_IN_EN:   in_en     <= wd;
        IX_OUT_EN:  out_en    <= wd;
        IX_OUT_VAL: out_val   <= wd;
        IX_PULL_EN: pull_en   <= wd;
        IX_DRIVE:   drive_q   <= wd;
        IX_RISE_EN: rise_en_q <= wd;
        IX_FALL_EN: fall_en_q <= wd;
        IX_HIGH_EN: high_en_q <= wd;
        IX_LOW_EN:  low_en_q  <= wd;
        IX_ALT_EN:  alt_en_q  <= wd;
        IX_ALT_SEL: alt_sel_q <= wd;
        IX_OUT_INV: out_inv   <= wd;
        default: ;
      endcase
    end
  end

  // Per-pin bundling of enables, clears and pending flags.
  for (genvar i = 0; i < NPINS; i++) begin : g_pack
    assign ie[i].rise  = rise_en_q[i];
    assign ie[i].fall  = fall_en_q[i];
    assign ie[i].high  = high_en_q[i];
    assign ie[i].low   = low_en_q[i];
    assign clr[i].rise = wr_ok && (ix == IX_RISE_PEND) && wd[i];
    assign clr[i].fall = wr_ok && (ix == IX_FALL_PEND) && wd[i];
    assign clr[i].high = wr_ok && (ix == IX_HIGH_PEND) && wd[i];
    assign clr[i].low  = wr_ok && (ix == IX_LOW_PEND)  && wd[i];
    assign rise_p[i]   = pend[i].rise;
    assign fall_p[i]   = pend[i].fall;
    assign high_p[i]   = pend[i].high;
    assign low_p[i]    = pend[i].low;
  end

  function automatic logic [DATA_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  always_comb begin
    case (ix)
      IX_SAMPLE:    rd_mux = widen(sample);
      IX_IN_EN:     rd_mux = widen(in_en);
      IX_OUT_EN:    rd_mux = widen(out_en);
      IX_OUT_VAL:   rd_mux = widen(out_val);
      IX_PULL_EN:   rd_mux = widen(pull_en);
      IX_DRIVE:     rd_mux = widen(drive_q);
      IX_RISE_EN:   rd_mux = widen(rise_en_q);
      IX_RISE_PEND: rd_mux = widen(rise_p);
      IX_FALL_EN:   rd_mux = widen(fall_en_q);
      IX_FALL_PEND: rd_mux = widen(fall_p);
      IX_HIGH_EN:   rd_mux = widen(high_en_q);
      IX_HIGH_PEND: rd_mux = widen(high_p);
      IX_LOW_EN:    rd_mux = widen(low_en_q);
      IX_LOW_PEND:  rd_mux = widen(low_p);
      IX_ALT_EN:    rd_mux = widen(alt_en_q);
      IX_ALT_SEL:   rd_mux = widen(alt_sel_q);
      IX_OUT_INV:   rd_mux = widen(out_inv);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_bad   <= 1'b0;
    end else begin
      bus_rdata <= (bus_rd && mapped) ? rd_mux : '0;
      bus_bad   <= bad_c;
    end
  end

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !mapped) |-> (bus_rdata == '0)); // R11
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0)); // R11

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_bad,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pin_drv,
  output logic [NPINS-1:0]  pin_level,
  output logic [NPINS-1:0]  pin_short,
  output logic [NPINS-1:0]  pin_irq
);

  localparam int SYNC_W = 2 * NPINS;

  logic [NPINS-1:0] in_en, out_en, out_val, pull_en, out_inv;
  logic [NPINS-1:0] in_s, drv_s, sample;
  evt_t [NPINS-1:0] ie, clr, pend;

  gpio_bank_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pin_drv, pin_in}),
    .q   ({drv_s, in_s})
  );

  gpio_bank_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_bad   (bus_bad),
    .in_en     (in_en),
    .out_en    (out_en),
    .out_val   (out_val),
    .pull_en   (pull_en),
    .out_inv   (out_inv),
    .ie        (ie),
    .clr       (clr),
    .sample    (sample),
    .pend      (pend)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_bank_pin u_pin (
      .clk      (clk),
      .rst      (rst),
      .ext_in   (in_s[i]),
      .ext_drv  (drv_s[i]),
      .in_en    (in_en[i]),
      .out_en   (out_en[i]),
      .out_val  (out_val[i]),
      .out_inv  (out_inv[i]),
      .pull_en  (pull_en[i]),
      .ie       (ie[i]),
      .clr      (clr[i]),
      .level_q  (pin_level[i]),
      .short_q  (pin_short[i]),
      .sample_q (sample[i]),
      .pend_q   (pend[i]),
      .irq_q    (pin_irq[i])
    );
  end

  AST_BAD_IS_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    bus_bad |-> $past(bus_wr || bus_rd)); // R11

endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;

  localparam logic [7:0] A_SAMPLE = 8'h00, A_IN_EN = 8'h04, A_OUT_EN = 8'h08,
    A_OUT_VAL = 8'h0C, A_PULL = 8'h10, A_DRIVE = 8'h14, A_RISE_EN = 8'h18,
    A_RISE_P = 8'h1C, A_FALL_EN = 8'h20, A_FALL_P = 8'h24, A_HIGH_EN = 8'h28,
    A_HIGH_P = 8'h2C, A_LOW_EN = 8'h30, A_LOW_P = 8'h34, A_ALT_EN = 8'h38,
    A_ALT_SEL = 8'h3C, A_OUT_INV = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_bad;
  logic [31:0] pin_in = '0, pin_drv = '0;
  logic [31:0] pin_level, pin_short, pin_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic rd_seen = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_bad(bus_bad), .pin_in(pin_in), .pin_drv(pin_drv),
    .pin_level(pin_level), .pin_short(pin_short), .pin_irq(pin_irq)
  );

  // Monitor: pops expected read data as the design returns it.
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty, got %h exp none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (bus_rdata !== e.exp) begin
          n_fail++;
          $display("FAIL %s got %h exp %h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected item.
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    sb_q.push_back('{tag, e});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(pin_level, 32'h0, "R9 level in reset");
    chk(pin_irq, 32'h0, "R9 irq in reset");
    chk({31'h0, bus_bad}, 32'h0, "R9 bad in reset");
    @(negedge clk);
    rst = 1'b0;
    rd(A_IN_EN, 32'h0, "R9 in_en after reset");
    rd(A_SAMPLE, 32'h0, "R9 sample after reset");
    chk(pin_short, 32'h0, "R9 short after reset");

    // R10: readback, storage-only registers
    wr(A_OUT_INV, 32'h00FF_00FF);
    wr(A_DRIVE, 32'h1234_5678);
    wr(A_ALT_SEL, 32'hCAFE_0001);
    wr(A_ALT_EN, 32'h8000_0003);
    rd(A_OUT_INV, 32'h00FF_00FF, "R10 inversion readback");
    rd(A_DRIVE, 32'h1234_5678, "R10 drive readback");
    rd(A_ALT_SEL, 32'hCAFE_0001, "R10 alt select readback");
    rd(A_ALT_EN, 32'h8000_0003, "R10 alt enable readback");

    // R1: own drive through inversion
    wr(A_OUT_EN, 32'hFFFF_FFFF);
    wr(A_OUT_VAL, 32'h0000_FFFF);
    settle();
    chk(pin_level, 32'h00FF_FF00, "R1 port xor inversion");
    wr(A_DRIVE, 32'hFFFF_FFFF);
    wr(A_ALT_EN, 32'hFFFF_FFFF);
    settle();
    chk(pin_level, 32'h00FF_FF00, "R10 storage regs no effect");

    // R2: priority external > own > pull
    wr(A_OUT_VAL, 32'h0);
    wr(A_OUT_INV, 32'h0300_0000);
    wr(A_OUT_EN, 32'h0F0F_0000);
    wr(A_PULL, 32'hF000_0000);
    @(negedge clk);
    pin_drv = 32'h0000_000F;
    pin_in  = 32'h0000_0005;
    settle();
    chk(pin_level, 32'hF300_0005, "R2 mixed priority");
    chk(pin_short, 32'h0, "R3 no collision");
    wr(A_OUT_EN, 32'h0F0F_0001);
    settle();
    chk(pin_short, 32'h0000_0001, "R3 collision pin0");
    chk(pin_level, 32'hF300_0005, "R2 external wins on collision");

    // R4: input gating
    rd(A_SAMPLE, 32'h0, "R4 sample gated off");
    wr(A_IN_EN, 32'hFFFF_FFFF);
    settle();
    rd(A_SAMPLE, 32'hF300_0005, "R4 sample follows level");

    // R12: synchronizer latency
    wr(A_OUT_EN, 32'h0);
    wr(A_PULL, 32'h0);
    @(negedge clk);
    pin_drv = 32'hFFFF_FFFF;
    pin_in  = 32'h0;
    settle();
    @(negedge clk);
    pin_in = 32'h0000_0100;
    @(negedge clk);
    chk(pin_level, 32'h0, "R12 edge1 unchanged");
    @(negedge clk);
    chk(pin_level, 32'h0, "R12 edge2 unchanged");
    @(negedge clk);
    chk(pin_level, 32'h0000_0100, "R12 edge3 updated");
    @(negedge clk);
    pin_in = 32'h0;
    settle();

    // R5, R7: level flags, set beats clear
    wr(A_RISE_P, 32'hFFFF_FFFF);
    wr(A_FALL_P, 32'hFFFF_FFFF);
    wr(A_HIGH_P, 32'hFFFF_FFFF);
    wr(A_LOW_P, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(A_LOW_P, 32'hFFFF_FFFF, "R7 low re-sets through clear");
    rd(A_HIGH_P, 32'h0, "R5 high clear with input low");
    rd(A_RISE_P, 32'h0, "R7 rise cleared");

    // R6: edges
    @(negedge clk);
    pin_in = 32'h0000_00F0;
    settle();
    rd(A_RISE_P, 32'h0000_00F0, "R6 rising edge");
    rd(A_HIGH_P, 32'h0000_00F0, "R5 high level");
    rd(A_FALL_P, 32'h0, "R6 no fall yet");
    wr(A_RISE_P, 32'h0000_0030);
    rd(A_RISE_P, 32'h0000_00C0, "R7 partial clear");
    @(negedge clk);
    pin_in = 32'h0;
    settle();
    rd(A_FALL_P, 32'h0000_00F0, "R6 falling edge");
    rd(A_HIGH_P, 32'h0000_00F0, "R5 high sticky after drop");

    // R8: interrupt combining
    wr(A_RISE_P, 32'hFFFF_FFFF);
    wr(A_FALL_P, 32'hFFFF_FFFF);
    wr(A_HIGH_P, 32'hFFFF_FFFF);
    wr(A_RISE_EN, 32'h1);
    wr(A_FALL_EN, 32'h2);
    wr(A_HIGH_EN, 32'h4);
    wr(A_LOW_EN, 32'h8);
    settle();
    chk(pin_irq, 32'h0000_0008, "R8 low only");
    @(negedge clk);
    pin_in = 32'h7;
    settle();
    chk(pin_irq, 32'h0000_000D, "R8 rise high low");
    @(negedge clk);
    pin_in = 32'h0;
    settle();
    chk(pin_irq, 32'h0000_000F, "R8 plus fall");
    wr(A_RISE_P, 32'h1);
    settle();
    chk(pin_irq, 32'h0000_000E, "R8 rise cleared");

    // R11: bad accesses
    wr(A_IN_EN, 32'h0000_FFFF);
    chk({31'h0, bus_bad}, 32'h0, "R11 good write no flag");
    rd(8'h44, 32'h0, "R11 unmapped read zero");
    chk({31'h0, bus_bad}, 32'h1, "R11 unmapped read flag");
    wr(8'h48, 32'hFFFF_FFFF);
    chk({31'h0, bus_bad}, 32'h1, "R11 unmapped write flag");
    wr(8'h06, 32'hFFFF_FFFF);
    chk({31'h0, bus_bad}, 32'h1, "R11 misaligned write flag");
    wr(A_SAMPLE, 32'hFFFF_FFFF);
    chk({31'h0, bus_bad}, 32'h1, "R11 sample write flag");
    rd(A_IN_EN, 32'h0000_FFFF, "R11 writes ignored");
    rd(A_SAMPLE, 32'h0, "R11 sample unchanged");
    @(negedge clk);
    chk({31'h0, bus_bad}, 32'h0, "R11 flag is a pulse");

    repeat (3) @(negedge clk);
    report();
  end

endmodule